// File: doc/BRIEF.md
# Half-Integer Clock Divider

The block divides an input clock by N−0.5, where N is a programmable integer. A modulo-N down counter runs on a derived count clock. That count clock is the input clock XORed with a feedback bit. The feedback bit comes from a divide-by-2 stage, which flips on every terminal count of the counter. Each flip inverts the count clock's polarity. The next count edge then arrives half an input period early, so every output period is one half-period shorter than N input periods.

An enable input gates the feedback into the XOR. With the enable low, the count clock is the input clock itself and the block becomes a plain divide-by-N. Both the divisor and the enable are configuration inputs. The divisor is captured while reset is held, and the enable is expected to stay steady outside reset. The divided clock is the counter's terminal-count signal.

Top module: `half_int_div`

## Requirements
- R1: With `en_i` high, consecutive rising edges of `clk_o` are spaced exactly 2N−1 half-periods of `clk_i` apart. This holds for every N from 2 up to 2^W−1.
- R2: With `en_i` low, consecutive rising edges of `clk_o` are spaced exactly 2N half-periods of `clk_i` apart.
- R3: While `rst_ni` is low, `clk_o` is low.
- R4: `div_i` is captured on rising edges of `clk_i` only while `rst_ni` is low, so `clk_i` must run during reset. Changing `div_i` after reset is released has no effect on the output spacing.
- R5: A `div_i` value of 0 or 1 is treated as N = 2.
- R6: After reset is released, the first rising edge of `clk_o` coincides with the (N−1)-th rising edge of `clk_i`. A counter that was reset to N−1 would behave the same way.
- R7: On each count-clock edge the counter decrements by one. When it reaches 0 it reloads N−1, and it never holds a value of N or more.
- R8: Each `clk_o` high phase lasts one half-period of `clk_i` when `en_i` is high, and one full period when `en_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Half-integer enable: high gives N−0.5, low gives N |
| div_i | input | W | Divisor N, captured during reset |
| clk_o | output | 1 | Divided clock (terminal-count pulse) |

## Verification
The bench times every rising edge of the output against the input half-period grid, for random and extreme divisors with the enable both high and low.

A design that swallowed the half cycle on the wrong polarity, or reloaded one count off, would show a spacing off by one or two half-periods. A divider that ignored the enable would give 2N−1 where 2N is expected.

Further runs do the following:
- drive divisors 0 and 1, which must behave as 2;
- change the divisor after reset, which must have no effect;
- check the first output edge after reset and the width of the high phase. These expose a wrong reset value of the counter or a terminal pulse of the wrong length.

// File: rtl/hid_pkg.sv
`timescale 1ns/1ps
package hid_pkg;
  localparam int unsigned HID_MIN_DIV = 2;

  function automatic logic [31:0] hid_clamp(input logic [31:0] n);
    return (n < HID_MIN_DIV) ? 32'(HID_MIN_DIV) : n;
  endfunction
endpackage

// File: rtl/hid_clk_mix.sv
`timescale 1ns/1ps
module hid_clk_mix (
  input  logic clk_i,
  input  logic en_i,
  input  logic flip_i,
  output logic ck_o
);
  // polarity swap swallows half an input period
  assign ck_o = clk_i ^ (en_i & flip_i);
endmodule

// File: rtl/hid_toggle.sv
`timescale 1ns/1ps
module hid_toggle (
  input  logic ck_i,
  input  logic rst_ni,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge ck_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= ~q_q;
  end

  assign q_o = q_q;
endmodule

// File: rtl/hid_down_cnt.sv
`timescale 1ns/1ps
module hid_down_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         ck_i,
  input  logic         rst_ni,
  input  logic [W-1:0] div_i,
  output logic [W-1:0] cnt_o,
  output logic         arm_o,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;
  logic         arm_q;

  // arm_q stands for the virtual reset value N-1; the first edge goes to N-2
  always_ff @(posedge ck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      arm_q <= 1'b1;
    end else if (arm_q) begin
      cnt_q <= div_i - W'(2);
      arm_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q <= div_i - W'(1);
    end else begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign arm_o = arm_q;
  assign tc_o  = (cnt_q == '0) && !arm_q;
endmodule

// File: rtl/half_int_div.sv
`timescale 1ns/1ps
module half_int_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         clk_o
);
  import hid_pkg::*;

  logic [W-1:0] div_q;
  logic [W-1:0] cnt;
  logic         arm;
  logic         tc;
  logic         flip;
  logic         cnt_ck;

  // divisor captured only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) div_q <= W'(hid_clamp(32'(div_i)));
  end

  hid_clk_mix u_mix (
    .clk_i  (clk_i),
    .en_i   (en_i),
    .flip_i (flip),
    .ck_o   (cnt_ck)
  );

  hid_down_cnt #(.W(W)) u_cnt (
    .ck_i   (cnt_ck),
    .rst_ni (rst_ni),
    .div_i  (div_q),
    .cnt_o  (cnt),
    .arm_o  (arm),
    .tc_o   (tc)
  );

  hid_toggle u_tog (
    .ck_i   (tc),
    .rst_ni (rst_ni),
    .q_o    (flip)
  );

  assign clk_o = tc;
endmodule

// File: rtl/hid_chk.sv
`timescale 1ns/1ps
module hid_chk #(
  parameter int unsigned W = 8
) (
  input logic         ck_i,
  input logic         rst_ni,
  input logic [W-1:0] cnt_i,
  input logic         arm_i,
  input logic [W-1:0] div_i
);
  p_dec_r7: assert property (@(posedge ck_i) disable iff (!rst_ni)
    (!arm_i && cnt_i != '0) |=> cnt_i == W'($past(cnt_i) - W'(1)));

  p_reload_r7: assert property (@(posedge ck_i) disable iff (!rst_ni)
    (!arm_i && cnt_i == '0) |=> cnt_i == W'(div_i - W'(1)));

  p_range_r7: assert property (@(posedge ck_i) disable iff (!rst_ni)
    !arm_i |-> cnt_i < div_i);

  p_arm_once_r6: assert property (@(posedge ck_i) disable iff (!rst_ni)
    arm_i |=> !arm_i);
endmodule

bind half_int_div hid_chk #(.W(W)) u_chk (
  .ck_i   (cnt_ck),
  .rst_ni (rst_ni),
  .cnt_i  (cnt),
  .arm_i  (arm),
  .div_i  (div_q)
);

// File: tb/half_int_div_tb.sv
`timescale 1ns/1ps
module half_int_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b1;
  logic [W-1:0] div_i = W'(2);
  logic         clk_o;

  int n_checks = 0;
  int n_fail = 0;

  half_int_div #(.W(W)) u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .div_i  (div_i),
    .clk_o  (clk_o)
  );

  always #(HALF) clk_i = ~clk_i;

  function automatic longint exp_spacing(input int n, input bit en);
    return en ? longint'(2 * n - 1) : longint'(2 * n);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // n_eff is the divisor the requirements predict; scramble changes div_i after reset
  task automatic run_case(input int n_drive, input int n_eff, input bit en,
                          input int reps, input bit scramble, input string tag);
    longint t_rel, t0, t1;
    rst_ni = 1'b0;
    en_i   = en;
    div_i  = W'(n_drive);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R3 clk_o low in reset", longint'(clk_o), 0);
    rst_ni = 1'b1;
    t_rel = $time;
    if (scramble) div_i = W'($urandom_range(2, 255));
    @(posedge clk_o);
    t0 = $time;
    chk("R6 first edge", (t0 - t_rel), longint'(HALF + CLK_PERIOD * (n_eff - 2)));
    @(negedge clk_o);
    chk("R8 high time", ($time - t0), en ? longint'(HALF) : longint'(CLK_PERIOD));
    for (int i = 0; i < reps; i++) begin
      @(posedge clk_o);
      t1 = $time;
      chk(tag, (t1 - t0) / HALF, exp_spacing(n_eff, en));
      t0 = t1;
    end
  endtask

  initial begin
    #(longint'(CLK_PERIOD) * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // directed corners
    run_case(2,   2,   1'b1, 4, 1'b0, "R1 N=2");
    run_case(3,   3,   1'b1, 4, 1'b0, "R1 N=3");
    run_case(255, 255, 1'b1, 3, 1'b0, "R1 N=max");
    run_case(2,   2,   1'b0, 4, 1'b0, "R2 N=2");
    run_case(255, 255, 1'b0, 2, 1'b0, "R2 N=max");
    run_case(0,   2,   1'b1, 3, 1'b0, "R5 N=0");
    run_case(1,   2,   1'b1, 3, 1'b0, "R5 N=1");
    run_case(1,   2,   1'b0, 3, 1'b0, "R5 N=1 plain");
    run_case(7,   7,   1'b1, 5, 1'b1, "R4 div change ignored");
    run_case(5,   5,   1'b0, 5, 1'b1, "R4 div change ignored plain");
    // random mix
    for (int k = 0; k < 40; k++) begin
      int n;
      bit en;
      n  = int'($urandom_range(2, 40));
      en = 1'($urandom_range(0, 1));
      run_case(n, n, en, 4, 1'($urandom_range(0, 1)), en ? "R1 random" : "R2 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule